// File: doc/BRIEF.md
# Pulse Timing and Corner-Turn Controller

This block sets the pulse-repetition timing of a pulse-Doppler receiver and generates the addresses that stack the received echoes into a pulse-by-sample matrix held in an external memory. A free-running interval timer produces a transmit gate. The gate is high for a fixed leading part of every repetition interval. The default interval is 3 ms and the gate is high for 20% of it. The rest of the interval is the receive window, and only strobes that arrive inside it are taken as digitized samples.

The block works in two phases. In the fill phase, each accepted sample is written at the address pulse × ROW_LEN + sample. The sample index counts up, and the pulse index moves on only when the sample index wraps, so each pulse fills one row. When the last sample of the last pulse has been written, the frame is complete and the drain phase starts. In the drain phase the block issues one read every clock cycle and walks down the columns: the pulse index is the fast counter, and the sample index advances after NUM_PULSES reads. A downstream Doppler transform therefore receives all pulses at one range bin in a row. Strobes that arrive during the drain phase are discarded. After the last read the block returns to the fill phase at address zero.

The defaults are 2^14 samples per row and 256 pulses per frame. All sizes are parameters, so a small configuration can be checked exhaustively.

Top module: `pulse_frame_ctrl`

## Requirements
- R1: `tx_gate` is high during cycles 0 to TX_CYC-1 of every PRI_CYC-cycle interval and low for the remaining cycles. The interval counter starts at cycle 0 in the first cycle after reset and runs freely.
- R2: A `smp_strobe` seen while `tx_gate` is high produces no write and does not advance the write position.
- R3: While filling, `wr_addr` equals pulse × ROW_LEN + sample, and `wr_en` follows each accepted strobe in the same cycle. The sample index advances on each accepted strobe, and the pulse index advances when the sample index wraps from ROW_LEN-1 to 0.
- R4: The accepted write at pulse NUM_PULSES-1, sample ROW_LEN-1 raises `frame_ready` in the next cycle and starts the drain phase.
- R5: While `frame_ready` is high, `rd_en` is high on every cycle and `rd_addr` equals pulse × ROW_LEN + column. The pulse index advances on every read, and the column advances after every NUM_PULSES reads.
- R6: `rd_col_last` is high exactly on drain reads whose pulse index is NUM_PULSES-1, and low at all other times.
- R7: Strobes are ignored while `frame_ready` is high. The cycle after the read at column ROW_LEN-1, pulse NUM_PULSES-1, `frame_ready` and `rd_en` are low and `wr_addr` is 0.
- R8: During reset, `tx_gate` is high (TX_CYC > 0), and `frame_ready`, `rd_en`, `wr_en`, `wr_addr` and `rd_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe | input | 1 | One digitized sample is available this cycle |
| tx_gate | output | 1 | Transmit window of the current repetition interval |
| wr_en | output | 1 | Write the current sample to the matrix memory |
| wr_addr | output | ADDR_W | Row-major write address |
| rd_en | output | 1 | Read request during column readout |
| rd_addr | output | ADDR_W | Column-major read address |
| rd_col_last | output | 1 | Current read is the last pulse of a column |
| frame_ready | output | 1 | A full frame is stored and is being read out |

## Verification
On every cycle the assertions check four things: no write while the gate is high or the frame is draining; each write address is one above the previous one within a frame; each read address is one row above the previous one within a column; and the phase changes happen at the final write and the final read. The exact position of the gate inside each interval, the column wrap to the next range bin, and the end-to-end address sequence under sparse, bursty and pseudo-random strobe patterns can only be shown by the bench scenarios. The bench compares every cycle against an arithmetic model.

// File: rtl/pulse_frame_pkg.sv
package pulse_frame_pkg;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    // Width of a counter that holds the values 0 .. n-1 (at least one bit)
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Linear address of matrix element (row, col) for a row of row_len entries
    function automatic int unsigned mat_addr(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned row_len);
        return row * row_len + col;
    endfunction

endpackage

// File: rtl/prt_pri_timer.sv
module prt_pri_timer
    import pulse_frame_pkg::*;
#(
    parameter int unsigned PRI_CYC = 375000,
    parameter int unsigned TX_CYC  = 75000
) (
    input  logic clk,
    input  logic rst,
    output logic tx_gate
);
    localparam int unsigned CW = idx_width(PRI_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (cnt == CW'(PRI_CYC - 1)) cnt <= '0;
        else                              cnt <= cnt + CW'(1);
    end

    assign tx_gate = ({1'b0, cnt} < (CW + 1)'(TX_CYC));

    // R1: the gate only opens at the start of an interval
    a_r1_gate_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_gate) |-> cnt == '0);

endmodule

// File: rtl/prt_idx_counter.sv
module prt_idx_counter
    import pulse_frame_pkg::*;
#(
    parameter int unsigned FAST_N = 16384,
    parameter int unsigned SLOW_N = 256
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           step,
    output logic [idx_width(FAST_N)-1:0]   fast,
    output logic [idx_width(SLOW_N)-1:0]   slow,
    output logic                           all_last
);
    localparam int unsigned FW = idx_width(FAST_N);
    localparam int unsigned SW = idx_width(SLOW_N);

    logic fast_end, slow_end;

    assign fast_end = (fast == FW'(FAST_N - 1));
    assign slow_end = (slow == SW'(SLOW_N - 1));
    assign all_last = fast_end && slow_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            fast <= '0;
            slow <= '0;
        end else if (step) begin
            if (fast_end) begin
                fast <= '0;
                slow <= slow_end ? '0 : slow + SW'(1);
            end else begin
                fast <= fast + FW'(1);
            end
        end
    end

    // R3/R5: both indices stay inside the matrix bounds
    a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, fast} < (FW + 1)'(FAST_N)) && ({1'b0, slow} < (SW + 1)'(SLOW_N)));

endmodule

// File: rtl/pulse_frame_ctrl.sv
module pulse_frame_ctrl
    import pulse_frame_pkg::*;
#(
    parameter int unsigned PRI_CYC    = 375000,
    parameter int unsigned TX_CYC     = 75000,
    parameter int unsigned ROW_LEN    = 16384,
    parameter int unsigned NUM_PULSES = 256,
    parameter int unsigned ADDR_W     = idx_width(ROW_LEN * NUM_PULSES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_strobe,
    output logic              tx_gate,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_col_last,
    output logic              frame_ready
);
    localparam int unsigned SW = idx_width(ROW_LEN);
    localparam int unsigned PW = idx_width(NUM_PULSES);

    phase_e        phase_q;
    logic          accept;
    logic          drain;
    logic [SW-1:0] w_samp;
    logic [PW-1:0] w_pulse;
    logic          w_all_last;
    logic [PW-1:0] r_pulse;
    logic [SW-1:0] r_col;
    logic          r_all_last;

    prt_pri_timer #(.PRI_CYC(PRI_CYC), .TX_CYC(TX_CYC)) u_timer (
        .clk(clk), .rst(rst), .tx_gate(tx_gate)
    );

    // Row-major writer: sample is the fast index, pulse the slow one
    prt_idx_counter #(.FAST_N(ROW_LEN), .SLOW_N(NUM_PULSES)) u_wr_idx (
        .clk(clk), .rst(rst), .step(accept),
        .fast(w_samp), .slow(w_pulse), .all_last(w_all_last)
    );

    // Column-major reader: pulse is the fast index, column the slow one
    prt_idx_counter #(.FAST_N(NUM_PULSES), .SLOW_N(ROW_LEN)) u_rd_idx (
        .clk(clk), .rst(rst), .step(drain),
        .fast(r_pulse), .slow(r_col), .all_last(r_all_last)
    );

    assign drain  = (phase_q == PH_DRAIN);
    assign accept = smp_strobe && !tx_gate && !drain;

    always_ff @(posedge clk) begin
        if (rst)                          phase_q <= PH_FILL;
        else if (!drain && accept && w_all_last) phase_q <= PH_DRAIN;
        else if (drain && r_all_last)     phase_q <= PH_FILL;
    end

    assign wr_en       = accept;
    assign wr_addr     = ADDR_W'(mat_addr(32'(w_pulse), 32'(w_samp), ROW_LEN));
    assign rd_en       = drain;
    assign rd_addr     = ADDR_W'(mat_addr(32'(r_pulse), 32'(r_col), ROW_LEN));
    assign rd_col_last = drain && (r_pulse == PW'(NUM_PULSES - 1));
    assign frame_ready = drain;

    // R2: nothing is written inside the transmit window
    a_r2_no_write_in_tx: assert property (@(posedge clk) disable iff (rst)
        tx_gate |-> !wr_en);

    // R7: writes are held off while the frame drains
    a_r7_no_write_in_drain: assert property (@(posedge clk) disable iff (rst)
        frame_ready |-> !wr_en);

    // R3: consecutive writes within a frame use consecutive addresses
    a_r3_wr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !w_all_last) |=> wr_addr == $past(wr_addr) + ADDR_W'(1));

    // R4: the final write of a frame starts the readout
    a_r4_ready_after_fill: assert property (@(posedge clk) disable iff (rst)
        (wr_en && w_all_last) |=> frame_ready);

    // R5: within a column each read moves down one row
    a_r5_rd_step: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_col_last) |=> rd_addr == $past(rd_addr) + ADDR_W'(ROW_LEN));

    // R7: the final read releases the memory for a new frame at address zero
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (rd_en && r_all_last) |=> (!frame_ready && wr_addr == '0));

endmodule

// File: tb/pulse_frame_ctrl_bench.sv
module pulse_frame_ctrl_bench;
    localparam int PRI    = 10;
    localparam int TX     = 2;
    localparam int ROW    = 4;
    localparam int NP     = 3;
    localparam int AW     = 4;
    localparam int FRAMES = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_strobe = 1'b0;
    logic          tx_gate, wr_en, rd_en, rd_col_last, frame_ready;
    logic [AW-1:0] wr_addr, rd_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pulse_frame_ctrl #(.PRI_CYC(PRI), .TX_CYC(TX), .ROW_LEN(ROW),
                       .NUM_PULSES(NP), .ADDR_W(AW)) u_pulse_frame_ctrl (
        .clk(clk), .rst(rst), .smp_strobe(smp_strobe), .tx_gate(tx_gate),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_col_last(rd_col_last), .frame_ready(frame_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int t = 0, ws = 0, wp = 0, rs = 0, rp = 0, frames = 0;
        bit rdph = 0;
        logic [15:0] lfsr = 16'hACE1;
        bit exp_tx, acc;

        // R8: reset state, strobe high to show it has no effect
        smp_strobe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 tx_gate", tx_gate, 1);
        chk("R8 frame_ready", frame_ready, 0);
        chk("R8 rd_en", rd_en, 0);
        chk("R8 wr_en", wr_en, 0);
        chk("R8 wr_addr", wr_addr, 0);
        chk("R8 rd_addr", rd_addr, 0);
        rst = 1'b0;

        while (frames < FRAMES) begin
            // strobe pattern per frame: dense, sparse, pseudo-random, dense
            case (frames % 4)
                0, 3: smp_strobe = 1'b1;
                1:    smp_strobe = (t % 3) != 0;
                default: smp_strobe = lfsr[0];
            endcase
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            exp_tx = (t % PRI) < TX;
            acc    = smp_strobe && !exp_tx && !rdph;
            chk("R1 tx_gate", tx_gate, int'(exp_tx));
            if (smp_strobe && exp_tx)  chk("R2 strobe in tx ignored", wr_en, 0);
            else if (smp_strobe && rdph) chk("R7 strobe in drain ignored", wr_en, 0);
            else                       chk("R3 wr_en", wr_en, int'(acc));
            chk("R3 wr_addr", wr_addr, wp * ROW + ws);
            chk("R4 frame_ready", frame_ready, int'(rdph));
            chk("R5 rd_en", rd_en, int'(rdph));
            if (rdph) chk("R5 rd_addr", rd_addr, rp * ROW + rs);
            chk("R6 rd_col_last", rd_col_last, int'(rdph && rp == NP - 1));

            // model of the coming clock edge
            if (!rdph) begin
                if (acc) begin
                    ws++;
                    if (ws == ROW) begin
                        ws = 0; wp++;
                        if (wp == NP) begin wp = 0; rdph = 1; end
                    end
                end
            end else begin
                rp++;
                if (rp == NP) begin
                    rp = 0; rs++;
                    if (rs == ROW) begin rs = 0; rdph = 0; frames++; end
                end
            end
            t++;
            @(negedge clk);
        end

        // R7: after the final read the writer is back at address zero
        #1;
        chk("R7 frame_ready after drain", frame_ready, 0);
        chk("R7 wr_addr after drain", wr_addr, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule